// File: doc/BRIEF.md
# Privileged Status Read Multiplexer

This block completes a privileged read-direct operation that copies internal processor state into a general register. When a request arrives, it decodes the low byte of the effective address into a source kind and a five-bit address. It then selects one of three sources:

- the three interrupt inhibit bits of the program status words;
- a word of low real memory at locations 0 to 31, fetched through a read port with a ready handshake;
- one of two internal control registers: the branch-from program counter or the load device address.

The block packs the selected value into fixed positions of a 32-bit word. Reserved positions are zero. It then pulses a register-file write strobe carrying the destination number taken from the request's R field.

A zero R field suppresses the write completely, and a zero R field on a memory request issues no memory read. Reserved control-register addresses and unknown source kinds raise a one-cycle reserved-access flag. The low-memory path holds a busy output until its write, and requests that arrive while busy are dropped.

Bits are numbered big-endian: bit 0 is the most significant bit of a word, so big-endian bit k is vector index 31-k. The `ea` port carries big-endian effective-address bits 24 to 31.

Top module: `status_read_mux`

## Requirements
- R1: When a request has a zero R field, `wr_en` never rises for it. If its kind is memory, `mem_rd` and `busy` stay low.
- R2: The kind code is `ea[7:5]` (big-endian bits 24-26) and the address is `ea[4:0]` (big-endian bits 27-31). Kind codes are 1 = inhibit read, 2 = low-memory read, 3 = control-register read. For any other kind code: no write occurs, and `rsv_flag` is high for exactly the one cycle after the request.
- R3: An inhibit read with a nonzero R field writes `{29 zeros, psw_inh}` in the cycle after the request. `psw_inh[2]` is the first PSW inhibit bit (PSW bit 37) and lands in destination big-endian bit 29, index 2.
- R4: A low-memory read with a nonzero R field sets `mem_rd` high from the cycle after the request, with `mem_addr` equal to the request address. `mem_rd` stays high until `mem_ready` is sampled high. In the next cycle, `wr_en` pulses with `wr_data` equal to the `mem_rdata` sampled with that ready.
- R5: `busy` is high from the cycle after an accepted memory request until the cycle in which its write appears, when it drops. A request presented while `busy` is high is ignored: it causes no write and no flag.
- R6: Control address 0x1D writes the 18-bit branch-from program counter into big-endian bits 14-31, indexes 17:0. Bits 0-13 are zero.
- R7: Control address 0x1F writes the 24-bit load device address into big-endian bits 8-31, indexes 23:0. Bits 0-7 are zero.
- R8: Any other control address writes all zeros (when the R field is nonzero). It raises `rsv_flag` for exactly the cycle in which that write appears.
- R9: Each write lasts a single cycle, and `wr_addr` equals the R field of the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid for one cycle |
| r_field | input | 4 | Destination register number |
| ea | input | 8 | Effective-address bits 24-31: kind and address |
| psw_inh | input | 3 | PSW interrupt inhibit bits 37-39 |
| mem_rd | output | 1 | Low-memory read request, held until ready |
| mem_addr | output | 5 | Low-memory word location 0-31 |
| mem_ready | input | 1 | Low-memory read data valid |
| mem_rdata | input | 32 | Low-memory read data |
| bfpc | input | 18 | Branch-from program counter |
| lda | input | 24 | Load device address |
| busy | output | 1 | Memory read in progress |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | 4 | Register-file write destination |
| wr_data | output | 32 | Register-file write data |
| rsv_flag | output | 1 | Reserved access flag |

## Verification
The inhibit read is tried with two different inhibit patterns, which shows that the three bits land at the low end in their own order and not reversed. The control read is tried on both defined addresses with non-symmetric values, and on a reserved address, which separates correct field placement from plain zero-extension and from reserved decoding. Memory reads use zero and several wait cycles at different locations, with a conflicting request injected while busy, to separate correct ready capture from early or repeated writes. Requests with a zero R field and unknown kind codes confirm that writes are suppressed while the flag is still raised.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_INH  = 2'd1,
        K_MEM  = 2'd2,
        K_CREG = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } state_e;
endpackage

// File: rtl/srm_decode.sv
module srm_decode
    import srm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int KIND_W = 3,
    localparam int EA_W = ADDR_W + KIND_W
) (
    input  logic [EA_W-1:0]   ea,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr
);
    logic [KIND_W-1:0] code;

    assign code = ea[EA_W-1:ADDR_W];
    assign addr = ea[ADDR_W-1:0];

    always_comb begin
        case (code)
            KIND_W'(1): kind = K_INH;
            KIND_W'(2): kind = K_MEM;
            KIND_W'(3): kind = K_CREG;
            default:    kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/srm_format.sv
module srm_format #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int INH_W   = 3,
    parameter int BFPC_W  = 18,
    parameter int LDA_W   = 24,
    parameter logic [ADDR_W-1:0] CR_BFPC = 5'h1D,
    parameter logic [ADDR_W-1:0] CR_LDA  = 5'h1F
) (
    input  logic [INH_W-1:0]  psw_inh,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BFPC_W-1:0] bfpc,
    input  logic [LDA_W-1:0]  lda,
    output logic [DATA_W-1:0] inh_word,
    output logic [DATA_W-1:0] cr_word,
    output logic              cr_rsv
);
    localparam int INH_PAD  = DATA_W - INH_W;
    localparam int BFPC_PAD = DATA_W - BFPC_W;
    localparam int LDA_PAD  = DATA_W - LDA_W;

    assign inh_word = {{INH_PAD{1'b0}}, psw_inh};

    always_comb begin
        cr_word = '0;
        cr_rsv  = 1'b0;
        if (addr == CR_BFPC) begin
            cr_word = {{BFPC_PAD{1'b0}}, bfpc};
        end else if (addr == CR_LDA) begin
            cr_word = {{LDA_PAD{1'b0}}, lda};
        end else begin
            cr_rsv = 1'b1;
        end
    end
endmodule

// File: rtl/status_read_mux.sv
module status_read_mux
    import srm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int KIND_W = 3,
    parameter int RF_W   = 4,
    parameter int INH_W  = 3,
    parameter int BFPC_W = 18,
    parameter int LDA_W  = 24,
    localparam int EA_W = ADDR_W + KIND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [RF_W-1:0]   r_field,
    input  logic [EA_W-1:0]   ea,
    input  logic [INH_W-1:0]  psw_inh,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [BFPC_W-1:0] bfpc,
    input  logic [LDA_W-1:0]  lda,
    output logic              busy,
    output logic              wr_en,
    output logic [RF_W-1:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rsv_flag
);
    typedef struct packed {
        state_e            state;
        logic              wr_en;
        logic [RF_W-1:0]   wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              rsv;
        logic [ADDR_W-1:0] mem_addr;
    } regs_t;

    regs_t             st_d, st_q;
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] inh_word, cr_word;
    logic              cr_rsv;
    logic              r_nz;

    srm_decode #(.ADDR_W(ADDR_W), .KIND_W(KIND_W)) u_decode (
        .ea   (ea),
        .kind (kind),
        .addr (addr)
    );

    srm_format #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INH_W(INH_W),
        .BFPC_W(BFPC_W), .LDA_W(LDA_W)
    ) u_format (
        .psw_inh  (psw_inh),
        .addr     (addr),
        .bfpc     (bfpc),
        .lda      (lda),
        .inh_word (inh_word),
        .cr_word  (cr_word),
        .cr_rsv   (cr_rsv)
    );

    assign r_nz = |r_field;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.rsv   = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (req) begin
                    st_d.wr_addr = r_field;
                    case (kind)
                        K_INH: begin
                            st_d.wr_en   = r_nz;
                            st_d.wr_data = inh_word;
                        end
                        K_MEM: begin
                            if (r_nz) begin
                                st_d.state    = ST_MEM;
                                st_d.mem_addr = addr;
                            end
                        end
                        K_CREG: begin
                            st_d.wr_en   = r_nz;
                            st_d.wr_data = cr_word;
                            st_d.rsv     = cr_rsv;
                        end
                        default: begin
                            st_d.rsv = 1'b1;
                        end
                    endcase
                end
            end
            ST_MEM: begin
                if (mem_ready) begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_data = mem_rdata;
                    st_d.state   = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.state == ST_MEM);
    assign mem_rd   = (st_q.state == ST_MEM);
    assign mem_addr = st_q.mem_addr;
    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.wr_addr;
    assign wr_data  = st_q.wr_data;
    assign rsv_flag = st_q.rsv;
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int KIND_W = 3,
    parameter int RF_W   = 4,
    parameter int INH_W  = 3,
    parameter int BFPC_W = 18,
    parameter int LDA_W  = 24,
    localparam int EA_W = ADDR_W + KIND_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [RF_W-1:0]   r_field,
    input logic [EA_W-1:0]   ea,
    input logic [INH_W-1:0]  psw_inh,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [BFPC_W-1:0] bfpc,
    input logic [LDA_W-1:0]  lda,
    input logic              busy,
    input logic              wr_en,
    input logic [RF_W-1:0]   wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rsv_flag
);
    logic              acc;
    logic [KIND_W-1:0] kcode;
    logic [ADDR_W-1:0] a;

    assign acc   = req && !busy && (r_field != '0);
    assign kcode = ea[EA_W-1:ADDR_W];
    assign a     = ea[ADDR_W-1:0];

    p_no_write_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr != '0);

    p_unknown_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && kcode != KIND_W'(1) && kcode != KIND_W'(2) && kcode != KIND_W'(3))
        |=> rsv_flag && !wr_en);

    p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kcode == KIND_W'(1))
        |=> wr_en && wr_data == {{(DATA_W-INH_W){1'b0}}, $past(psw_inh)});

    p_mem_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kcode == KIND_W'(2)) |=> mem_rd && mem_addr == $past(a) && !wr_en);

    p_mem_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> wr_en && !busy && wr_data == $past(mem_rdata));

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> busy && mem_rd && !wr_en && !rsv_flag);

    p_bfpc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kcode == KIND_W'(3) && a == 5'h1D)
        |=> wr_en && !rsv_flag && wr_data == {{(DATA_W-BFPC_W){1'b0}}, $past(bfpc)});

    p_lda_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kcode == KIND_W'(3) && a == 5'h1F)
        |=> wr_en && !rsv_flag && wr_data == {{(DATA_W-LDA_W){1'b0}}, $past(lda)});

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_flag && wr_en) |-> wr_data == '0);

    p_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kcode != KIND_W'(2) && kcode != '0 && kcode <= KIND_W'(3))
        |=> wr_en && wr_addr == $past(r_field));
endmodule

bind status_read_mux srm_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .RF_W(RF_W),
    .INH_W(INH_W), .BFPC_W(BFPC_W), .LDA_W(LDA_W)
) u_srm_checker (.*);

// File: tb/test_status_read_mux.sv
module test_status_read_mux;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  r_field = '0;
    logic [7:0]  ea = '0;
    logic [2:0]  psw_inh = '0;
    logic        mem_rd;
    logic [4:0]  mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [17:0] bfpc = '0;
    logic [23:0] lda = '0;
    logic        busy, wr_en, rsv_flag;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    status_read_mux i_status_read_mux (
        .clk(clk), .rst_n(rst_n), .req(req), .r_field(r_field), .ea(ea),
        .psw_inh(psw_inh), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .bfpc(bfpc), .lda(lda),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsv_flag(rsv_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] r, input logic [2:0] k, input logic [4:0] a);
        @(negedge clk);
        req = 1'b1; r_field = r; ea = {k, a};
        @(negedge clk);
        req = 1'b0; r_field = '0; ea = '0;
    endtask

    task automatic t_reset;
        chk("R9 reset wr_en", 32'(wr_en), 0);
        chk("R5 reset busy", 32'(busy), 0);
        chk("R4 reset mem_rd", 32'(mem_rd), 0);
        chk("R8 reset rsv_flag", 32'(rsv_flag), 0);
    endtask

    task automatic t_inhibit;
        psw_inh = 3'b101;
        issue(4'd7, 3'd1, 5'd0);
        chk("R3 inhibit wr_en", 32'(wr_en), 1);
        chk("R3 inhibit data 101", wr_data, 32'h5);
        chk("R9 inhibit wr_addr", 32'(wr_addr), 7);
        @(negedge clk);
        chk("R9 single-cycle strobe", 32'(wr_en), 0);
        psw_inh = 3'b110;
        issue(4'd1, 3'd1, 5'd13);
        chk("R3 inhibit data 110", wr_data, 32'h6);
        chk("R9 inhibit wr_addr 1", 32'(wr_addr), 1);
    endtask

    task automatic t_rzero;
        issue(4'd0, 3'd1, 5'd0);
        chk("R1 zero R inhibit no write", 32'(wr_en), 0);
        issue(4'd0, 3'd2, 5'd4);
        chk("R1 zero R mem no read", 32'(mem_rd), 0);
        chk("R1 zero R mem no busy", 32'(busy), 0);
        chk("R1 zero R mem no write", 32'(wr_en), 0);
        issue(4'd0, 3'd3, 5'h1D);
        chk("R1 zero R creg no write", 32'(wr_en), 0);
    endtask

    task automatic t_creg;
        bfpc = 18'h2ABCD;
        lda  = 24'hC0FFEE;
        issue(4'd3, 3'd3, 5'h1D);
        chk("R6 bfpc wr_en", 32'(wr_en), 1);
        chk("R6 bfpc data", wr_data, 32'h0002ABCD);
        chk("R6 bfpc no flag", 32'(rsv_flag), 0);
        issue(4'd4, 3'd3, 5'h1F);
        chk("R7 lda data", wr_data, 32'h00C0FFEE);
        chk("R7 lda wr_addr", 32'(wr_addr), 4);
        issue(4'd5, 3'd3, 5'h05);
        chk("R8 reserved wr_en", 32'(wr_en), 1);
        chk("R8 reserved data zero", wr_data, 32'h0);
        chk("R8 reserved flag", 32'(rsv_flag), 1);
        @(negedge clk);
        chk("R8 flag one cycle", 32'(rsv_flag), 0);
        issue(4'd5, 3'd3, 5'h1E);
        chk("R8 reserved 1E flag", 32'(rsv_flag), 1);
        chk("R8 reserved 1E data", wr_data, 32'h0);
    endtask

    task automatic t_unknown;
        issue(4'd6, 3'd0, 5'd1);
        chk("R2 kind 0 no write", 32'(wr_en), 0);
        chk("R2 kind 0 flag", 32'(rsv_flag), 1);
        issue(4'd6, 3'd7, 5'd1);
        chk("R2 kind 7 no write", 32'(wr_en), 0);
        chk("R2 kind 7 flag", 32'(rsv_flag), 1);
        @(negedge clk);
        chk("R2 flag one cycle", 32'(rsv_flag), 0);
    endtask

    task automatic t_mem(input logic [3:0] r, input logic [4:0] a,
                         input int waits, input logic [31:0] d);
        issue(r, 3'd2, a);
        for (int i = 0; i <= waits; i++) begin
            chk("R5 busy while waiting", 32'(busy), 1);
            chk("R4 mem_rd held", 32'(mem_rd), 1);
            chk("R4 mem_addr", 32'(mem_addr), 32'(a));
            chk("R4 no early write", 32'(wr_en), 0);
            if (i == waits) begin
                mem_ready = 1'b1; mem_rdata = d;
            end
            @(negedge clk);
            mem_ready = 1'b0; mem_rdata = 32'hFFFF_FFFF;
        end
        chk("R4 mem write strobe", 32'(wr_en), 1);
        chk("R4 mem data", wr_data, d);
        chk("R9 mem wr_addr", 32'(wr_addr), 32'(r));
        chk("R5 busy drops with write", 32'(busy), 0);
        chk("R4 mem_rd drops", 32'(mem_rd), 0);
        @(negedge clk);
        chk("R9 mem single strobe", 32'(wr_en), 0);
    endtask

    task automatic t_ignore;
        issue(4'd2, 3'd2, 5'd9);
        chk("R5 busy after request", 32'(busy), 1);
        req = 1'b1; r_field = 4'd5; ea = {3'd1, 5'd0};
        @(negedge clk);
        req = 1'b0; r_field = '0; ea = '0;
        chk("R5 ignored request no write", 32'(wr_en), 0);
        chk("R5 still busy", 32'(busy), 1);
        mem_ready = 1'b1; mem_rdata = 32'h1234_5678;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R5 write answers first request", 32'(wr_addr), 2);
        chk("R4 data after ignore", wr_data, 32'h1234_5678);
        @(negedge clk);
        chk("R5 no late write from ignored", 32'(wr_en), 0);
        chk("R5 no flag from ignored", 32'(rsv_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_inhibit();
        t_rzero();
        t_creg();
        t_unknown();
        t_mem(4'd1, 5'd3, 2, 32'hDEAD_BEEF);
        t_mem(4'd15, 5'd31, 0, 32'h8000_0001);
        t_mem(4'd9, 5'd0, 5, 32'h0F0F_0F0F);
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule